// File: doc/BRIEF.md
# Per-Pin Interrupt Redirection Controller

This block sits between a set of external interrupt pins and a message sender that carries interrupt requests to processors. Each pin owns a programmable entry that says how the pin is read (active high or active low, edge or level), whether it is masked, and what the outgoing request carries: an 8-bit vector, a 3-bit delivery mode, a destination mode and an 8-bit destination. When a pin becomes ready, the block presents a request on a valid/ready handshake. The request is held until the sender accepts it.

Edge pins remember one pending request. Level pins are gated by a remote service flag. Acceptance sets that flag, and only an end-of-interrupt carrying the pin's vector clears it. If the pin is still active at that point, a new request is raised. Software reads and writes entries through a simple addressed port. Two status bits can be read back: pending and remote service.

Top module: `irq_route_ctl`

## Requirements
- R1: After reset every entry reads 0x0040_0000: mask set (bit 22), all other configuration fields zero, pending (bit 24) and remote service (bit 25) clear. No request is presented.
- R2: The write word layout is: vector [7:0], destination [15:8], delivery mode [18:16], destination mode [19] (1 = logical), trigger [20] (1 = level), active-low polarity [21], mask [22]. A read of the same pin returns these bits unchanged.
- R3: Polarity is applied before any detection. A pin programmed active low raises nothing while its input is high, and is treated as active while its input is low.
- R4: An edge pin raises one pending request on each inactive-to-active transition of its synchronised, polarity-corrected input. Further transitions while that request is still pending merge into it, so a single acceptance clears them all.
- R5: A level pin requests while it is active and its remote service bit is clear. Acceptance sets remote service, and no further request is raised while remote service stays set.
- R6: An end-of-interrupt clears remote service on level entries whose vector equals the end-of-interrupt vector, and on no others. If the pin is still active, the request reappears on the next cycle. If the pin is inactive, no request follows.
- R7: Remote service is never set on an edge pin.
- R8: A masked pin presents no request and shows no pending status. Clearing the mask of an active level pin raises its request.
- R9: When several pins are ready, the lowest-numbered pin is presented first, and one pin is served per accepted handshake.
- R10: In physical destination mode only the low PHYS_BITS (default 4) destination bits reach req_dest; the upper bits read zero. In logical mode all 8 bits are passed.
- R11: A presented request carries the vector, delivery mode and destination mode of the winning entry. That entry's pending bit reads 1 until the request is accepted.
- R12: If an acceptance and a matching end-of-interrupt for the same level pin fall in one cycle, acceptance wins and remote service ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | NPIN | Asynchronous interrupt inputs |
| cfg_we | input | 1 | Entry write strobe |
| cfg_addr | input | IW | Pin index for write and read |
| cfg_wdata | input | 23 | Entry configuration word |
| cfg_rdata | output | 32 | Addressed entry with pending [24] and remote service [25] |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Sender accepts the request |
| req_pin | output | IW | Pin being served |
| req_vector | output | 8 | Vector of the request |
| req_mode | output | 3 | Delivery mode of the request |
| req_dmode | output | 1 | Destination mode (1 = logical) |
| req_dest | output | 8 | Destination, trimmed in physical mode |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being retired |

## Verification
Acceptance of a level request and an end-of-interrupt for the same vector can land on one clock edge. One updates the remote service bit and the other clears it. The bench provokes this by first releasing the flag with an end-of-interrupt while the input is held active, so the request is presented again. On the following cycle it raises req_ready and eoi_valid together with the same vector. It then reads the entry back and expects remote service set and no new request, because acceptance takes priority.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   localparam int VEC_W  = 8;
   localparam int DEST_W = 8;
   localparam int MODE_W = 3;

   // Entry configuration; packed order fixes the register bit positions.
   typedef struct packed {
      logic              mask;     // 22
      logic              act_low;  // 21
      logic              lvl;      // 20
      logic              logical;  // 19
      logic [MODE_W-1:0] mode;     // 18:16
      logic [DEST_W-1:0] dest;     // 15:8
      logic [VEC_W-1:0]  vec;      // 7:0
   } ent_cfg_t;

   localparam int CFG_W   = $bits(ent_cfg_t);
   localparam int RD_W    = 32;
   localparam int PEND_B  = 24;
   localparam int RIRR_B  = 25;

   localparam ent_cfg_t ENT_RST = '{mask: 1'b1, default: '0};

endpackage

// File: rtl/irq_in_sync.sv
module irq_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic act_low,
   output logic active,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;
   logic              active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg    <= '0;
         active_q <= 1'b0;
      end else begin
         shreg    <= {shreg[STAGES-2:0], pin};
         active_q <= active;
      end
   end

   assign active = shreg[STAGES-1] ^ act_low;
   assign rise   = active & ~active_q;

endmodule

// File: rtl/irq_pin_state.sv
module irq_pin_state
   import irq_route_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr,
   input  ent_cfg_t wdata,
   input  logic     active,
   input  logic     rise,
   input  logic     grant,
   input  logic     eoi_valid,
   input  logic [VEC_W-1:0] eoi_vector,
   output ent_cfg_t cfg,
   output logic     ready,
   output logic     rirr
);

   logic pend;
   logic eoi_hit;

   assign eoi_hit = eoi_valid && (eoi_vector == cfg.vec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= ENT_RST;
         pend <= 1'b0;
         rirr <= 1'b0;
      end else begin
         if (wr) cfg <= wdata;
         if (cfg.lvl) begin
            pend <= 1'b0;
            // acceptance outranks a same-cycle EOI
            rirr <= grant | (rirr & ~eoi_hit);
         end else begin
            // new edge outranks a same-cycle acceptance
            pend <= (rise & ~cfg.mask) | (pend & ~grant);
            rirr <= 1'b0;
         end
      end
   end

   assign ready = ~cfg.mask & (cfg.lvl ? (active & ~rirr) : pend);

endmodule

// File: rtl/irq_pick_low.sv
module irq_pick_low #(
   parameter int N  = 8,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
   import irq_route_pkg::*;
#(
   parameter int NPIN        = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PHYS_BITS   = 4,
   localparam int IW         = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPIN-1:0]   pin_raw,
   input  logic              cfg_we,
   input  logic [IW-1:0]     cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [RD_W-1:0]   cfg_rdata,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [IW-1:0]     req_pin,
   output logic [VEC_W-1:0]  req_vector,
   output logic [MODE_W-1:0] req_mode,
   output logic              req_dmode,
   output logic [DEST_W-1:0] req_dest,
   input  logic              eoi_valid,
   input  logic [VEC_W-1:0]  eoi_vector
);

   if (NPIN < 1 || NPIN > 64) begin : g_bad_npin
      $error("irq_route_ctl: NPIN out of range");
   end
   if (PHYS_BITS < 1 || PHYS_BITS > DEST_W) begin : g_bad_phys
      $error("irq_route_ctl: PHYS_BITS out of range");
   end

   ent_cfg_t        cfg_arr [NPIN];
   logic [NPIN-1:0] rdy_v, rirr_v, lvl_v, mask_v, grant_v;
   logic            accept;
   ent_cfg_t        sel;

   assign accept = req_valid & req_ready;

   for (genvar k = 0; k < NPIN; k++) begin : g_pin
      logic active, rise;

      irq_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .pin     (pin_raw[k]),
         .act_low (cfg_arr[k].act_low),
         .active  (active),
         .rise    (rise)
      );

      assign grant_v[k] = accept && (req_pin == IW'(k));

      irq_pin_state u_state (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr         (cfg_we && (cfg_addr == IW'(k))),
         .wdata      (ent_cfg_t'(cfg_wdata)),
         .active     (active),
         .rise       (rise),
         .grant      (grant_v[k]),
         .eoi_valid  (eoi_valid),
         .eoi_vector (eoi_vector),
         .cfg        (cfg_arr[k]),
         .ready      (rdy_v[k]),
         .rirr       (rirr_v[k])
      );

      assign lvl_v[k]  = cfg_arr[k].lvl;
      assign mask_v[k] = cfg_arr[k].mask;
   end

   irq_pick_low #(.N(NPIN), .IW(IW)) u_pick (
      .req (rdy_v),
      .any (req_valid),
      .idx (req_pin)
   );

   assign sel        = cfg_arr[req_pin];
   assign req_vector = sel.vec;
   assign req_mode   = sel.mode;
   assign req_dmode  = sel.logical;

   if (PHYS_BITS == DEST_W) begin : g_dest_full
      assign req_dest = sel.dest;
   end else begin : g_dest_trim
      localparam logic [DEST_W-1:0] PHYS_MASK = {{(DEST_W-PHYS_BITS){1'b0}}, {PHYS_BITS{1'b1}}};
      assign req_dest = sel.logical ? sel.dest : (sel.dest & PHYS_MASK);
   end

   always_comb begin
      cfg_rdata                 = '0;
      cfg_rdata[CFG_W-1:0]      = cfg_arr[cfg_addr];
      cfg_rdata[PEND_B]         = rdy_v[cfg_addr];
      cfg_rdata[RIRR_B]         = rirr_v[cfg_addr];
   end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
   parameter int NPIN      = 8,
   parameter int IW        = 3,
   parameter int PHYS_BITS = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic            req_valid,
   input logic            req_ready,
   input logic [IW-1:0]   req_pin,
   input logic            req_dmode,
   input logic [7:0]      req_dest,
   input logic [NPIN-1:0] rdy_v,
   input logic [NPIN-1:0] rirr_v,
   input logic [NPIN-1:0] lvl_v,
   input logic [NPIN-1:0] mask_v
);

   logic [NPIN-1:0] below;
   always_comb begin
      below = '0;
      for (int i = 0; i < NPIN; i++) begin
         if (IW'(i) < req_pin) below[i] = 1'b1;
      end
   end

   p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !mask_v[req_pin]);

   p_lowest_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (rdy_v[req_pin] && ((rdy_v & below) == '0)));

   p_rirr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && lvl_v[req_pin] && !cfg_we) |=> rirr_v[$past(req_pin)]);

   p_rirr_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && lvl_v[req_pin]) |-> !rirr_v[req_pin]);

   p_edge_no_rirr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((~lvl_v) & ~$past(lvl_v) & rirr_v) == '0);

   p_phys_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_dmode) |-> ((req_dest >> PHYS_BITS) == 8'd0));

endmodule

bind irq_route_ctl irq_route_chk #(.NPIN(NPIN), .IW(IW), .PHYS_BITS(PHYS_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_pin   (req_pin),
   .req_dmode (req_dmode),
   .req_dest  (req_dest),
   .rdy_v     (rdy_v),
   .rirr_v    (rirr_v),
   .lvl_v     (lvl_v),
   .mask_v    (mask_v)
);

// File: tb/test_irq_route_ctl.sv
module test_irq_route_ctl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pin_raw = 8'h10;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [22:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [2:0]  req_pin;
   logic [7:0]  req_vector;
   logic [2:0]  req_mode;
   logic        req_dmode;
   logic [7:0]  req_dest;
   logic        eoi_valid = 1'b0;
   logic [7:0]  eoi_vector = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   irq_route_ctl i_irq_route_ctl (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_pin(req_pin),
      .req_vector(req_vector), .req_mode(req_mode), .req_dmode(req_dmode), .req_dest(req_dest),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
   );

   function automatic logic [22:0] pack(input logic [7:0] vec, input logic [7:0] dest,
      input logic [2:0] mode, input logic logical, input logic lvl,
      input logic alow, input logic mask);
      return {mask, alow, lvl, logical, mode, dest, vec};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] p, input logic [22:0] d);
      cfg_we = 1'b1; cfg_addr = p; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] p, output logic [31:0] d);
      cfg_addr = p;
      #1 d = cfg_rdata;
   endtask

   task automatic accept_one();
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
   endtask

   task automatic send_eoi(input logic [7:0] v);
      eoi_valid = 1'b1; eoi_vector = v;
      @(negedge clk);
      eoi_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int p = 0; p < 8; p++) begin
         rd(3'(p), d);
         chk($sformatf("R1 reset entry %0d", p), d, 32'h0040_0000);
      end
      chk("R1 no request after reset", {31'b0, req_valid}, 32'd0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(3'd3, pack(8'h5A, 8'hC3, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1));
      rd(3'd3, d);
      chk("R2 readback layout", d, {9'b0, pack(8'h5A, 8'hC3, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1)});
   endtask

   task automatic t_edge();
      logic [31:0] d;
      wr(3'd2, pack(8'h21, 8'h37, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
      pin_raw[2] = 1'b1; cyc(2); pin_raw[2] = 1'b0; cyc(4);
      chk("R4 edge raises request", {31'b0, req_valid}, 32'd1);
      chk("R11 pin of request", {29'b0, req_pin}, 32'd2);
      chk("R11 vector", {24'b0, req_vector}, 32'h21);
      chk("R10 physical dest trimmed", {24'b0, req_dest}, 32'h07);
      rd(3'd2, d);
      chk("R11 pending bit", {31'b0, d[24]}, 32'd1);
      pin_raw[2] = 1'b1; cyc(2); pin_raw[2] = 1'b0; cyc(4);
      accept_one();
      chk("R4 merged edges cleared by one accept", {31'b0, req_valid}, 32'd0);
      cyc(3);
      chk("R4 no second request", {31'b0, req_valid}, 32'd0);
      rd(3'd2, d);
      chk("R7 edge pin remote service clear", {31'b0, d[25]}, 32'd0);
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr(3'd4, pack(8'h40, 8'hAB, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0));
      cyc(4);
      chk("R3 active-low pin high stays quiet", {31'b0, req_valid}, 32'd0);
      pin_raw[4] = 1'b0; cyc(4);
      chk("R3 active-low pin low requests", {31'b0, req_valid}, 32'd1);
      chk("R11 level pin index", {29'b0, req_pin}, 32'd4);
      chk("R10 logical dest full", {24'b0, req_dest}, 32'hAB);
      chk("R11 mode and dmode", {28'b0, req_mode, req_dmode}, {28'b0, 3'd1, 1'b1});
      accept_one();
      cyc(2);
      chk("R5 no request while remote service set", {31'b0, req_valid}, 32'd0);
      rd(3'd4, d);
      chk("R5 remote service set", {31'b0, d[25]}, 32'd1);
      send_eoi(8'h41); cyc(1);
      rd(3'd4, d);
      chk("R6 other vector leaves flag", {31'b0, d[25]}, 32'd1);
      chk("R6 other vector no request", {31'b0, req_valid}, 32'd0);
      send_eoi(8'h40);
      chk("R6 active pin re-requests", {31'b0, req_valid}, 32'd1);
      // collision: accept and matching EOI on one edge
      req_ready = 1'b1; eoi_valid = 1'b1; eoi_vector = 8'h40;
      @(negedge clk);
      req_ready = 1'b0; eoi_valid = 1'b0;
      rd(3'd4, d);
      chk("R12 accept wins over EOI", {31'b0, d[25]}, 32'd1);
      chk("R12 no request after collision", {31'b0, req_valid}, 32'd0);
      pin_raw[4] = 1'b1; cyc(4);
      send_eoi(8'h40); cyc(2);
      chk("R6 inactive pin stays quiet", {31'b0, req_valid}, 32'd0);
      rd(3'd4, d);
      chk("R6 flag cleared", {31'b0, d[25]}, 32'd0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      wr(3'd6, pack(8'h66, 8'h01, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1));
      pin_raw[6] = 1'b1; cyc(4);
      chk("R8 masked pin no request", {31'b0, req_valid}, 32'd0);
      rd(3'd6, d);
      chk("R8 masked pin not pending", {31'b0, d[24]}, 32'd0);
      wr(3'd6, pack(8'h66, 8'h01, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0));
      chk("R8 unmask raises request", {28'b0, req_valid, req_pin}, {28'b0, 1'b1, 3'd6});
      wr(3'd6, pack(8'h66, 8'h01, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1));
      pin_raw[6] = 1'b0;
      chk("R8 remask drops request", {31'b0, req_valid}, 32'd0);
   endtask

   task automatic t_prio();
      wr(3'd1, pack(8'h11, 8'h02, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
      wr(3'd3, pack(8'h33, 8'h03, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
      pin_raw[1] = 1'b1; pin_raw[3] = 1'b1; cyc(2);
      pin_raw[1] = 1'b0; pin_raw[3] = 1'b0; cyc(4);
      chk("R9 lowest pin first", {24'b0, req_vector}, 32'h11);
      accept_one();
      chk("R9 next pin after accept", {28'b0, req_valid, req_pin}, {28'b0, 1'b1, 3'd3});
      accept_one();
      chk("R9 queue drained", {31'b0, req_valid}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_regs();
      t_edge();
      t_level();
      t_mask();
      t_prio();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule